// File: doc/BRIEF.md
# Disk Controller Function and Status Register

This block is the 18-bit control and status word of a head-per-track disk controller. The processor drives it with I/O pulses. Each pulse is a 3-bit pulse field plus a 2-bit sub-select. The block decodes these into five operations: clear the flags, test for a skip, clear the whole word, read the word back, and load the word. It holds the interrupt-enable, busy and write-direction control bits, and it keeps the latched error and completion flags. From these it derives an error summary bit and an interrupt request.

A load never replaces the control bits outright. The surviving control bits are XORed with the incoming word, so software can toggle them. After every operation, and after every flag event from the transfer engine, the block recomputes three things: the summary bit, the rule that completion drops busy, and the interrupt request.

A load that leaves busy set produces a one-cycle start strobe toward the transfer engine, unless a transfer is already running. A load that leaves busy clear produces a one-cycle cancel strobe if a transfer is running.

Top module: `dskfs_ctrl`

## Requirements
- R1: The word layout, from bit 17 down, is:

  | Bit | Meaning |
  |---|---|
  | 17 | error summary |
  | 16 | parity error |
  | 15 | illegal address |
  | 14 | timing error |
  | 13 | not ready |
  | 12 | done |
  | 11 | interrupt enable |
  | 10 | busy |
  | 9 | write |

  Bits 8..0 always read as zero, whatever was loaded.
- R2: Pulse bit 0 with sub-select 0 clears bits 17..12. Bits 11..9 are unchanged.
- R3: Pulse bit 0 with sub-select 1 raises `skip_o` in the same cycle when bit 17 or bit 12 is set, and otherwise keeps it low. The word is unchanged.
- R4: Pulse bit 0 with sub-select 2 clears the whole word.
- R5: Pulse bit 1 with sub-select 1 places the current word on `rdata_o` in the same cycle. In all other cycles `rdata_o` is zero.
- R6: Pulse bit 2 with sub-select 2 loads the word. The new word is the surviving bits 11..9 XORed with the input word, with bits 8..0 of the input masked off. Pulse bits 1 and 2 with any other sub-select leave the word unchanged.
- R7: After every update, bit 17 is set exactly when any of bits 16..13 is set.
- R8: After every update, busy (bit 10) is clear whenever done (bit 12) is set.
- R9: `irq_o` is high exactly when bit 11 is set and bit 17 or bit 12 is set.
- R10: If a load sets busy and `xfer_active_i` is low, `start_o` pulses for one cycle on the cycle after the load. If `xfer_active_i` is high, `start_o` does not pulse.
- R11: If a load leaves busy clear and `xfer_active_i` is high, `cancel_o` pulses for one cycle on the cycle after the load.
- R12: `flag_set_i` bits 4..0 set word bits 16..12 respectively. They are applied in the same cycle, after any pulse operation, so a flag set in the same cycle as a clear survives. R7, R8 and R9 apply to the result.
- R13: A synchronous reset clears the word. Busy, done, `irq_o`, `start_o` and `cancel_o` are all low after reset.
- R14: Pulse bits 0 and 2 together with sub-select 2 clear the word first and then load. The result is the masked input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_i | input | 3 | I/O pulse field |
| sel_i | input | 2 | Sub-select |
| wdata_i | input | 18 | Word from the processor |
| flag_set_i | input | 5 | Flag set events: parity, illegal address, timing, not ready, done |
| xfer_active_i | input | 1 | A transfer is in progress |
| rdata_o | output | 18 | Read-back bus |
| skip_o | output | 1 | Skip response |
| irq_o | output | 1 | Interrupt request |
| start_o | output | 1 | Start-transfer strobe |
| cancel_o | output | 1 | Cancel-transfer strobe |

## Verification
A wrong bit in the held word shows on `rdata_o` at the next status read. It also shows in the same cycle on `irq_o` whenever interrupt enable is involved, and on `skip_o` at the next skip test. A faulty summary or busy normalization becomes visible one cycle after the flag event or load that should have corrected it. A mistake in the start/cancel decision shows on the strobes exactly one cycle after the load.

// File: rtl/dskfs_pkg.sv
package dskfs_pkg;

   // Sub-select codes shared by decode and checks
   localparam logic [1:0] SEL_GRP0 = 2'd0;
   localparam logic [1:0] SEL_GRP1 = 2'd1;
   localparam logic [1:0] SEL_GRP2 = 2'd2;

   // One decoded pulse may assert several operations at once
   typedef struct packed {
      logic clr_flags;
      logic skip_q;
      logic clr_all;
      logic rd_stat;
      logic ld_stat;
   } fs_op_t;

endpackage

// File: rtl/dskfs_decode.sv
module dskfs_decode
   import dskfs_pkg::*;
(
   input  logic [2:0] pulse_i,
   input  logic [1:0] sel_i,
   output fs_op_t     op_o
);

   always_comb begin
      op_o           = '0;
      op_o.clr_flags = pulse_i[0] && (sel_i == SEL_GRP0);
      op_o.skip_q    = pulse_i[0] && (sel_i == SEL_GRP1);
      op_o.clr_all   = pulse_i[0] && (sel_i == SEL_GRP2);
      op_o.rd_stat   = pulse_i[1] && (sel_i == SEL_GRP1);
      op_o.ld_stat   = pulse_i[2] && (sel_i == SEL_GRP2);
   end

endmodule

// File: rtl/dskfs_core.sv
module dskfs_core #(
   parameter int STAT_W = 18,
   parameter int ZERO_W = 9,
   parameter int ERR_N  = 4,
   localparam int FLAG_W = ERR_N + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr_flags_i,
   input  logic              clr_all_i,
   input  logic              ld_stat_i,
   input  logic [STAT_W-1:0] wdata_i,
   input  logic [FLAG_W-1:0] flag_set_i,
   output logic [STAT_W-1:0] stat_o,
   output logic              ld_busy_o,
   output logic              irq_o
);

   localparam int SUM_B  = STAT_W - 1;
   localparam int ERR_HI = STAT_W - 2;
   localparam int ERR_LO = STAT_W - 1 - ERR_N;
   localparam int DONE_B = ERR_LO - 1;
   localparam int IE_B   = DONE_B - 1;
   localparam int BSY_B  = IE_B - 1;
   localparam int WR_B   = BSY_B - 1;
   localparam logic [STAT_W-1:0] ONE       = 1;
   localparam logic [STAT_W-1:0] CTL_MASK  = (ONE << IE_B) | (ONE << BSY_B) | (ONE << WR_B);
   localparam logic [STAT_W-1:0] ZERO_MASK = (ONE << ZERO_W) - ONE;

   if (WR_B != ZERO_W) begin : g_bad_layout
      $error("dskfs_core: STAT_W must equal ZERO_W + ERR_N + 5");
   end
   if (ERR_N < 1) begin : g_bad_errn
      $error("dskfs_core: ERR_N must be at least 1");
   end

   logic [STAT_W-1:0] stat_q;
   logic [STAT_W-1:0] s_clr, s_ld, s_flg, stat_d;
   logic [ERR_N-1:0]  err_vec;

   // Stage 1: clear operations
   always_comb begin
      s_clr = stat_q;
      if (clr_flags_i) s_clr[SUM_B:DONE_B] = '0;
      if (clr_all_i)   s_clr = '0;
   end

   // Stage 2: XOR load over the surviving control bits
   always_comb begin
      s_ld = s_clr;
      if (ld_stat_i) s_ld = (s_clr & CTL_MASK) ^ (wdata_i & ~ZERO_MASK);
   end

   assign ld_busy_o = s_ld[BSY_B];

   // Stage 3: external flag events land after the pulse operation
   always_comb begin
      s_flg                 = s_ld;
      s_flg[ERR_HI:DONE_B]  = s_ld[ERR_HI:DONE_B] | flag_set_i;
   end

   // Error summary gathered flag by flag
   for (genvar gi = 0; gi < ERR_N; gi++) begin : g_err
      assign err_vec[gi] = s_flg[ERR_LO + gi];
   end

   // Stage 4: normalization
   always_comb begin
      stat_d               = s_flg;
      stat_d[ZERO_W-1:0]   = '0;
      stat_d[SUM_B]        = |err_vec;
      if (s_flg[DONE_B]) stat_d[BSY_B] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) stat_q <= '0;
      else     stat_q <= stat_d;
   end

   assign stat_o = stat_q;
   assign irq_o  = stat_q[IE_B] && (stat_q[SUM_B] || stat_q[DONE_B]);

   // R1: low field never holds ones
   a_r1_low_zero: assert property (@(posedge clk) disable iff (rst)
      stat_q[ZERO_W-1:0] == '0);
   // R7: summary tracks the individual error flags
   a_r7_summary: assert property (@(posedge clk) disable iff (rst)
      stat_q[SUM_B] == (|stat_q[ERR_HI:ERR_LO]));
   // R8: completion and busy never coexist
   a_r8_done_drops_busy: assert property (@(posedge clk) disable iff (rst)
      stat_q[DONE_B] |-> !stat_q[BSY_B]);
   // R12: a done event is visible on the next cycle
   a_r12_done_sticks: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(flag_set_i[0])) |-> stat_q[DONE_B]);
   // R12: an error event raises the summary next cycle
   a_r12_err_sticks: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(flag_set_i[FLAG_W-1])) |-> stat_q[SUM_B]);
   // R13: reset leaves the word empty
   a_r13_reset_clear: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (stat_q == '0));

endmodule

// File: rtl/dskfs_strobe.sv
module dskfs_strobe #(
   parameter bit STROBE_REG = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic ld_fire_i,
   input  logic ld_busy_i,
   input  logic active_i,
   output logic start_o,
   output logic cancel_o
);

   logic start_d, cancel_d;

   assign start_d  = ld_fire_i && ld_busy_i && !active_i;
   assign cancel_d = ld_fire_i && !ld_busy_i && active_i;

   if (STROBE_REG) begin : g_reg
      logic start_q, cancel_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            start_q  <= 1'b0;
            cancel_q <= 1'b0;
         end else begin
            start_q  <= start_d;
            cancel_q <= cancel_d;
         end
      end
      assign start_o  = start_q;
      assign cancel_o = cancel_q;

      // R10: a start follows a busy load while idle
      a_r10_start_cause: assert property (@(posedge clk) disable iff (rst)
         start_o |-> ($past(ld_fire_i) && $past(ld_busy_i) && !$past(active_i)));
      // R11: a cancel follows a non-busy load while active
      a_r11_cancel_cause: assert property (@(posedge clk) disable iff (rst)
         cancel_o |-> ($past(ld_fire_i) && !$past(ld_busy_i) && $past(active_i)));
   end else begin : g_comb
      assign start_o  = start_d;
      assign cancel_o = cancel_d;
   end

   // R10 R11: the two strobes are exclusive
   a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
      !(start_o && cancel_o));

endmodule

// File: rtl/dskfs_ctrl.sv
module dskfs_ctrl #(
   parameter int STAT_W       = 18,
   parameter int ZERO_W       = 9,
   parameter int ERR_N        = 4,
   parameter bit RD_ZERO_IDLE = 1'b1,
   parameter bit STROBE_REG   = 1'b1,
   localparam int FLAG_W = ERR_N + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [2:0]        pulse_i,
   input  logic [1:0]        sel_i,
   input  logic [STAT_W-1:0] wdata_i,
   input  logic [FLAG_W-1:0] flag_set_i,
   input  logic              xfer_active_i,
   output logic [STAT_W-1:0] rdata_o,
   output logic              skip_o,
   output logic              irq_o,
   output logic              start_o,
   output logic              cancel_o
);
   import dskfs_pkg::*;

   localparam int SUM_B  = STAT_W - 1;
   localparam int DONE_B = STAT_W - 2 - ERR_N;

   fs_op_t            op;
   logic [STAT_W-1:0] stat;
   logic              ld_busy;

   dskfs_decode u_decode (
      .pulse_i (pulse_i),
      .sel_i   (sel_i),
      .op_o    (op)
   );

   dskfs_core #(
      .STAT_W (STAT_W),
      .ZERO_W (ZERO_W),
      .ERR_N  (ERR_N)
   ) u_core (
      .clk         (clk),
      .rst         (rst),
      .clr_flags_i (op.clr_flags),
      .clr_all_i   (op.clr_all),
      .ld_stat_i   (op.ld_stat),
      .wdata_i     (wdata_i),
      .flag_set_i  (flag_set_i),
      .stat_o      (stat),
      .ld_busy_o   (ld_busy),
      .irq_o       (irq_o)
   );

   dskfs_strobe #(
      .STROBE_REG (STROBE_REG)
   ) u_strobe (
      .clk       (clk),
      .rst       (rst),
      .ld_fire_i (op.ld_stat),
      .ld_busy_i (ld_busy),
      .active_i  (xfer_active_i),
      .start_o   (start_o),
      .cancel_o  (cancel_o)
   );

   assign skip_o = op.skip_q && (stat[SUM_B] || stat[DONE_B]);

   if (RD_ZERO_IDLE) begin : g_rd_gated
      assign rdata_o = op.rd_stat ? stat : '0;
   end else begin : g_rd_open
      assign rdata_o = stat;
   end

   // R3: skip only answers a skip query
   a_r3_skip_only_on_query: assert property (@(posedge clk) disable iff (rst)
      skip_o |-> (pulse_i[0] && (sel_i == SEL_GRP1)));
   // R9: interrupt request needs an event flag
   a_r9_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
      irq_o |-> (stat[SUM_B] || stat[DONE_B]));

endmodule

// File: tb/dskfs_ctrl_tb_top.sv
`timescale 1ns/1ps
module dskfs_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  pulse = '0;
   logic [1:0]  sel = '0;
   logic [17:0] wdata = '0;
   logic [4:0]  flags = '0;
   logic        active = 1'b0;
   logic [17:0] rdata;
   logic        skip, irq, start, cancel;

   always #4 clk = ~clk;   // 125 MHz

   dskfs_ctrl dut_i (
      .clk           (clk),
      .rst           (rst),
      .pulse_i       (pulse),
      .sel_i         (sel),
      .wdata_i       (wdata),
      .flag_set_i    (flags),
      .xfer_active_i (active),
      .rdata_o       (rdata),
      .skip_o        (skip),
      .irq_o         (irq),
      .start_o       (start),
      .cancel_o      (cancel)
   );

   typedef struct {
      string       req;
      logic [17:0] rd;
      logic        sk;
      logic        ir;
      logic        st;
      logic        cn;
   } exp_t;

   exp_t        sb_q[$];
   int          n_chk = 0;
   int          n_bad = 0;
   bit          finished = 0;

   // Requirement-level model state
   logic [17:0] m_s  = '0;
   logic        m_st = 1'b0;
   logic        m_cn = 1'b0;

   task automatic cmp(input string req, input string what, input logic [17:0] act, input logic [17:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %o expected %o", req, what, act, exp);
      end
   endtask

   task automatic op(input string req, input logic [2:0] p, input logic [1:0] s,
                     input logic [17:0] w, input logic [4:0] f, input logic act);
      exp_t        e;
      logic [17:0] n;
      logic        ld;
      @(negedge clk);
      pulse = p; sel = s; wdata = w; flags = f; active = act;
      e.req = req;
      e.rd  = (p[1] && s == 2'd1) ? m_s : 18'd0;
      e.sk  = p[0] && (s == 2'd1) && (m_s[17] || m_s[12]);
      e.ir  = m_s[11] && (m_s[17] || m_s[12]);
      e.st  = m_st;
      e.cn  = m_cn;
      sb_q.push_back(e);
      n = m_s;
      if (p[0] && s == 2'd0) n[17:12] = '0;
      if (p[0] && s == 2'd2) n = '0;
      ld = p[2] && (s == 2'd2);
      if (ld) n = (n & 18'o007000) ^ (w & ~18'o000777);
      m_st = ld && n[10] && !act;
      m_cn = ld && !n[10] && act;
      n[16:12] = n[16:12] | f;
      n[8:0] = '0;
      n[17] = |n[16:13];
      if (n[12]) n[10] = 1'b0;
      m_s = n;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; pulse = '0; sel = '0; wdata = '0; flags = '0; active = 1'b0;
      m_s = '0; m_st = 1'b0; m_cn = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   // Monitor: compares each cycle's outputs against the queued expectation
   initial begin
      forever begin
         @(negedge clk);
         #3;
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            cmp(e.req, "rdata",  rdata,         e.rd);
            cmp(e.req, "skip",   {17'd0, skip}, {17'd0, e.sk});
            cmp(e.req, "irq",    {17'd0, irq},  {17'd0, e.ir});
            cmp(e.req, "start",  {17'd0, start},{17'd0, e.st});
            cmp(e.req, "cancel", {17'd0, cancel},{17'd0, e.cn});
         end
      end
   end

   initial begin
      do_reset();
      op("R13 reset state",        3'b010, 2'd1, 18'o0,      5'd0,     1'b0);
      op("R5 idle bus",            3'b000, 2'd0, 18'o0,      5'd0,     1'b0);
      op("R6 R10 load ie busy",    3'b100, 2'd2, 18'o006000, 5'd0,     1'b0);
      op("R6 R10 read",            3'b010, 2'd1, 18'o0,      5'd0,     1'b0);
      op("R6 R10 reload active",   3'b100, 2'd2, 18'o000000, 5'd0,     1'b1);
      op("R6 read xor keep",       3'b010, 2'd1, 18'o0,      5'd0,     1'b1);
      op("R11 toggle busy off",    3'b100, 2'd2, 18'o002000, 5'd0,     1'b1);
      op("R11 read",               3'b010, 2'd1, 18'o0,      5'd0,     1'b0);
      op("R12 R9 done event",      3'b000, 2'd0, 18'o0,      5'b00001, 1'b0);
      op("R3 skip on done",        3'b001, 2'd1, 18'o0,      5'd0,     1'b0);
      op("R2 clear flags",         3'b001, 2'd0, 18'o0,      5'd0,     1'b0);
      op("R3 skip quiet",          3'b001, 2'd1, 18'o0,      5'd0,     1'b0);
      op("R7 parity event",        3'b000, 2'd0, 18'o0,      5'b10000, 1'b0);
      op("R7 read summary",        3'b010, 2'd1, 18'o0,      5'd0,     1'b0);
      op("R2 clear keeps ctl",     3'b001, 2'd0, 18'o0,      5'd0,     1'b0);
      op("R1 load low ones",       3'b100, 2'd2, 18'o001777, 5'd0,     1'b0);
      op("R1 read",                3'b010, 2'd1, 18'o0,      5'd0,     1'b0);
      op("R8 load busy done",      3'b100, 2'd2, 18'o012000, 5'd0,     1'b0);
      op("R8 read",                3'b010, 2'd1, 18'o0,      5'd0,     1'b0);
      op("R6 other select",        3'b100, 2'd0, 18'o777777, 5'd0,     1'b0);
      op("R5 other select",        3'b010, 2'd2, 18'o0,      5'd0,     1'b0);
      op("R6 ignored read",        3'b010, 2'd1, 18'o0,      5'd0,     1'b0);
      op("R4 clear all",           3'b001, 2'd2, 18'o0,      5'd0,     1'b0);
      op("R4 read",                3'b010, 2'd1, 18'o0,      5'd0,     1'b0);
      op("R6 load ie busy",        3'b100, 2'd2, 18'o006000, 5'd0,     1'b1);
      op("R14 clear then load",    3'b101, 2'd2, 18'o305123, 5'd0,     1'b0);
      op("R14 read",               3'b010, 2'd1, 18'o0,      5'd0,     1'b0);
      op("R12 flag during clear",  3'b001, 2'd0, 18'o0,      5'b00010, 1'b0);
      op("R12 read",               3'b010, 2'd1, 18'o0,      5'd0,     1'b0);
      op("R9 ie with error",       3'b100, 2'd2, 18'o004000, 5'b01000, 1'b0);
      op("R9 read",                3'b010, 2'd1, 18'o0,      5'd0,     1'b0);
      op("R10 busy load",          3'b100, 2'd2, 18'o002000, 5'd0,     1'b0);
      do_reset();
      op("R13 reset after run",    3'b010, 2'd1, 18'o0,      5'd0,     1'b0);
      op("R13 idle",               3'b000, 2'd0, 18'o0,      5'd0,     1'b0);
      @(negedge clk);
      @(negedge clk);
      #5;
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule